// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block holds the forwarding windows of a bus-to-bus bridge and decides, for every address it is shown, whether that address belongs behind the bridge. There are three windows. The IO window has 4 KB granularity. The non-prefetchable memory window and the prefetchable memory window each have 1 MB granularity. A register also holds the bus numbers and a latency value. Software programs all of this through a simple indexed write port. The register contents can be read back on the same port, and reads are combinational.

Two decode ports run side by side. The upstream port accepts a 40-bit memory address or a 25-bit IO address. The downstream port accepts a 32-bit address of either kind. Each port raises one flag per window plus an aggregate flag that means the access targets the secondary bus. The windows themselves are 32 bits wide. Upstream memory addresses above 4 GB therefore never match. An upstream IO address is extended with zeros. A downstream IO address with anything set above bit 24 is rejected.

Top module: `bridge_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, all four configuration registers read as zero.
- R2: Index 0 is the bus register: primary bus [7:0], secondary bus [15:8], subordinate bus [23:16], latency [31:24]. All 32 bits are writable, and a write is visible on the read port from the clock edge that samples `cfg_wr_en` onward.
- R3: Index 1 holds the IO window, with base in bits [12:0] and limit in bits [28:16]. Index 2 holds the non-prefetchable window and index 3 the prefetchable window, each with base in bits [15:4] and limit in bits [31:20]. All other bits of indices 1 to 3 read as zero.
- R4: A memory access whose 32-bit address has bits [31:20] between the non-prefetchable base and limit, both ends included, raises the non-prefetchable hit.
- R5: The prefetchable hit follows the same inclusive rule, using the fields at index 3.
- R6: An upstream memory address with any of bits [39:32] set raises neither memory hit.
- R7: An IO access hits when address bits [24:12] lie between the IO base and the IO limit, both ends included. On the upstream port, only `up_addr[24:0]` takes part in this comparison.
- R8: A downstream IO access with any of bits [31:25] set never raises the IO hit.
- R9: A window whose base is greater than its limit matches no address.
- R10: An IO access never raises a memory hit, and a memory access never raises the IO hit.
- R11: On each port, the target flag is set exactly when at least one of that port's three hit flags is set.
- R12: Hit outputs follow the presented address and kind in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index for both write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the indexed register |
| up_addr | input | 40 | Upstream address |
| up_is_io | input | 1 | Upstream access is IO (1) or memory (0) |
| dn_addr | input | 32 | Downstream address |
| dn_is_io | input | 1 | Downstream access is IO (1) or memory (0) |
| up_io_hit | output | 1 | Upstream address inside IO window |
| up_np_hit | output | 1 | Upstream address inside non-prefetchable window |
| up_pf_hit | output | 1 | Upstream address inside prefetchable window |
| up_target | output | 1 | Upstream access targets secondary bus |
| dn_io_hit | output | 1 | Downstream address inside IO window |
| dn_np_hit | output | 1 | Downstream address inside non-prefetchable window |
| dn_pf_hit | output | 1 | Downstream address inside prefetchable window |
| dn_target | output | 1 | Downstream access targets secondary bus |

## Verification
The hardest situations to reach are the ones where a hit depends on bits outside the compared field. Examples are an upstream IO address whose discarded high bits are nonzero but whose low 25 bits fall inside the window, and a 40-bit memory address that would match if its top byte were ignored. The stimulus first programs small windows at known places. It then aims addresses exactly at each base and limit and one granule beyond them. It repeats those addresses with high bits set, and it flips the access kind on addresses taken from the other window type. Disabled windows come from rewriting a base one granule above its limit, and random reprogramming during a long mixed run covers the remaining combinations.

// File: rtl/bwd_pkg.sv
`timescale 1ns/1ps
// Package: shared register index encoding for the bridge window decoder.
// Assumes a four-entry configuration space addressed by a 2-bit index.
package bwd_pkg;
    localparam int REG_IDX_W = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_BUSNUM = 2'd0,
        REG_IO_WIN = 2'd1,
        REG_NP_WIN = 2'd2,
        REG_PF_WIN = 2'd3
    } cfg_reg_e;

    localparam int NUM_MEM_WIN = 2;
endpackage

// File: rtl/bwd_cfg_regs.sv
`timescale 1ns/1ps
// Module: bwd_cfg_regs
// Holds the bus register and the three window base/limit pairs.
// Writes land on the clock edge that samples wr_en; reads are combinational.
// Assumes DATA_W is 32 so that the field positions fit the register map.
module bwd_cfg_regs
    import bwd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IO_FIELD_W  = 13,
    parameter int MEM_FIELD_W = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic [REG_IDX_W-1:0]                     idx,
    input  logic [DATA_W-1:0]                        wr_data,
    output logic [DATA_W-1:0]                        rd_data,
    output logic [IO_FIELD_W-1:0]                    io_base,
    output logic [IO_FIELD_W-1:0]                    io_limit,
    output logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]  mem_base,
    output logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0]  mem_limit
);
    localparam int IO_BASE_LSB   = 0;
    localparam int IO_LIMIT_LSB  = DATA_W / 2;
    localparam int MEM_BASE_LSB  = 4;
    localparam int MEM_LIMIT_LSB = DATA_W - MEM_FIELD_W;

    logic [DATA_W-1:0]                       bus_q;
    logic [IO_FIELD_W-1:0]                   io_base_q;
    logic [IO_FIELD_W-1:0]                   io_limit_q;
    logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_base_q;
    logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_limit_q;

    // Bus number and latency register: whole word is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (wr_en && idx == REG_BUSNUM) begin
            bus_q <= wr_data;
        end
    end

    // IO window base and limit fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_base_q  <= '0;
            io_limit_q <= '0;
        end else if (wr_en && idx == REG_IO_WIN) begin
            io_base_q  <= wr_data[IO_BASE_LSB  +: IO_FIELD_W];
            io_limit_q <= wr_data[IO_LIMIT_LSB +: IO_FIELD_W];
        end
    end

    // One register per memory window, at consecutive indices.
    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
        localparam int IDX_INT = int'(REG_NP_WIN) + w;
        localparam logic [REG_IDX_W-1:0] MY_IDX = IDX_INT[REG_IDX_W-1:0];

        // Memory window w base and limit fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_base_q[w]  <= '0;
                mem_limit_q[w] <= '0;
            end else if (wr_en && idx == MY_IDX) begin
                mem_base_q[w]  <= wr_data[MEM_BASE_LSB  +: MEM_FIELD_W];
                mem_limit_q[w] <= wr_data[MEM_LIMIT_LSB +: MEM_FIELD_W];
            end
        end
    end

    // Read mux: unimplemented bits return zero.
    always_comb begin
        rd_data = '0;
        case (cfg_reg_e'(idx))
            REG_BUSNUM: rd_data = bus_q;
            REG_IO_WIN: begin
                rd_data[IO_BASE_LSB  +: IO_FIELD_W] = io_base_q;
                rd_data[IO_LIMIT_LSB +: IO_FIELD_W] = io_limit_q;
            end
            REG_NP_WIN: begin
                rd_data[MEM_BASE_LSB  +: MEM_FIELD_W] = mem_base_q[0];
                rd_data[MEM_LIMIT_LSB +: MEM_FIELD_W] = mem_limit_q[0];
            end
            REG_PF_WIN: begin
                rd_data[MEM_BASE_LSB  +: MEM_FIELD_W] = mem_base_q[1];
                rd_data[MEM_LIMIT_LSB +: MEM_FIELD_W] = mem_limit_q[1];
            end
            default: rd_data = '0;
        endcase
    end

    assign io_base   = io_base_q;
    assign io_limit  = io_limit_q;
    assign mem_base  = mem_base_q;
    assign mem_limit = mem_limit_q;
endmodule

// File: rtl/bwd_range_match.sv
`timescale 1ns/1ps
// Module: bwd_range_match
// Inclusive base/limit comparison at field granularity.
// A window whose base exceeds its limit is treated as switched off.
module bwd_range_match #(
    parameter int FIELD_W = 12
) (
    input  logic               qualify,
    input  logic [FIELD_W-1:0] value,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] limit,
    output logic               hit
);
    logic enabled;

    // Window is live only when base does not exceed limit.
    always_comb enabled = (base <= limit);

    // Inclusive comparison at both ends.
    always_comb hit = qualify && enabled && (value >= base) && (value <= limit);
endmodule

// File: rtl/bwd_side_decode.sv
`timescale 1ns/1ps
// Module: bwd_side_decode
// Decodes one address port against the three windows.
// MASK_IO_HIGH=1: IO bits above UP_IO_W are discarded (narrow IO source).
// MASK_IO_HIGH=0: IO bits above UP_IO_W must be zero or no IO hit occurs.
// Memory bits above DN_ADDR_W, when present, must be zero to hit.
module bwd_side_decode
    import bwd_pkg::*;
#(
    parameter int ADDR_W        = 40,
    parameter int DN_ADDR_W     = 32,
    parameter int UP_IO_W       = 25,
    parameter int IO_GRAN_BITS  = 12,
    parameter int MEM_GRAN_BITS = 20,
    parameter bit MASK_IO_HIGH  = 1'b1
) (
    input  logic [ADDR_W-1:0]                              addr,
    input  logic                                           is_io,
    input  logic [UP_IO_W-IO_GRAN_BITS-1:0]                io_base,
    input  logic [UP_IO_W-IO_GRAN_BITS-1:0]                io_limit,
    input  logic [NUM_MEM_WIN-1:0][DN_ADDR_W-MEM_GRAN_BITS-1:0] mem_base,
    input  logic [NUM_MEM_WIN-1:0][DN_ADDR_W-MEM_GRAN_BITS-1:0] mem_limit,
    output logic                                           io_hit,
    output logic                                           np_hit,
    output logic                                           pf_hit,
    output logic                                           target
);
    localparam int IO_FIELD_W  = UP_IO_W - IO_GRAN_BITS;
    localparam int MEM_FIELD_W = DN_ADDR_W - MEM_GRAN_BITS;

    logic                   mem_ok;
    logic                   io_ok;
    logic [NUM_MEM_WIN-1:0] mem_hits;

    // Memory qualifier: only the lowest 4 GB can reach the windows.
    if (ADDR_W > DN_ADDR_W) begin : g_wide_mem
        assign mem_ok = !is_io && !(|addr[ADDR_W-1:DN_ADDR_W]);
    end else begin : g_narrow_mem
        assign mem_ok = !is_io;
    end

    // IO qualifier: drop or reject the bits above the narrow IO space.
    if (MASK_IO_HIGH) begin : g_io_mask
        assign io_ok = is_io;
    end else begin : g_io_reject
        assign io_ok = is_io && !(|addr[DN_ADDR_W-1:UP_IO_W]);
    end

    bwd_range_match #(.FIELD_W(IO_FIELD_W)) u_io (
        .qualify (io_ok),
        .value   (addr[UP_IO_W-1:IO_GRAN_BITS]),
        .base    (io_base),
        .limit   (io_limit),
        .hit     (io_hit)
    );

    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
        bwd_range_match #(.FIELD_W(MEM_FIELD_W)) u_mem (
            .qualify (mem_ok),
            .value   (addr[DN_ADDR_W-1:MEM_GRAN_BITS]),
            .base    (mem_base[w]),
            .limit   (mem_limit[w]),
            .hit     (mem_hits[w])
        );
    end

    // Split the memory results and form the aggregate flag.
    always_comb begin
        np_hit = mem_hits[0];
        pf_hit = mem_hits[1];
        target = io_hit | (|mem_hits);
    end
endmodule

// File: rtl/bridge_window_decoder.sv
`timescale 1ns/1ps
// Module: bridge_window_decoder (top)
// Configuration registers plus two combinational decode ports, one per
// side of the bridge. Assumes CFG_DATA_W of 32 for the register layout.
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int UP_ADDR_W     = 40,
    parameter int DN_ADDR_W     = 32,
    parameter int UP_IO_W       = 25,
    parameter int IO_GRAN_BITS  = 12,
    parameter int MEM_GRAN_BITS = 20,
    parameter int CFG_DATA_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [REG_IDX_W-1:0]  cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    input  logic [UP_ADDR_W-1:0]  up_addr,
    input  logic                  up_is_io,
    input  logic [DN_ADDR_W-1:0]  dn_addr,
    input  logic                  dn_is_io,
    output logic                  up_io_hit,
    output logic                  up_np_hit,
    output logic                  up_pf_hit,
    output logic                  up_target,
    output logic                  dn_io_hit,
    output logic                  dn_np_hit,
    output logic                  dn_pf_hit,
    output logic                  dn_target
);
    localparam int IO_FIELD_W  = UP_IO_W - IO_GRAN_BITS;
    localparam int MEM_FIELD_W = DN_ADDR_W - MEM_GRAN_BITS;

    logic [IO_FIELD_W-1:0]                   io_base;
    logic [IO_FIELD_W-1:0]                   io_limit;
    logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_base;
    logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_limit;

    bwd_cfg_regs #(
        .DATA_W      (CFG_DATA_W),
        .IO_FIELD_W  (IO_FIELD_W),
        .MEM_FIELD_W (MEM_FIELD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .idx       (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_data   (cfg_rdata),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .mem_base  (mem_base),
        .mem_limit (mem_limit)
    );

    bwd_side_decode #(
        .ADDR_W        (UP_ADDR_W),
        .DN_ADDR_W     (DN_ADDR_W),
        .UP_IO_W       (UP_IO_W),
        .IO_GRAN_BITS  (IO_GRAN_BITS),
        .MEM_GRAN_BITS (MEM_GRAN_BITS),
        .MASK_IO_HIGH  (1'b1)
    ) u_up (
        .addr      (up_addr),
        .is_io     (up_is_io),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .mem_base  (mem_base),
        .mem_limit (mem_limit),
        .io_hit    (up_io_hit),
        .np_hit    (up_np_hit),
        .pf_hit    (up_pf_hit),
        .target    (up_target)
    );

    bwd_side_decode #(
        .ADDR_W        (DN_ADDR_W),
        .DN_ADDR_W     (DN_ADDR_W),
        .UP_IO_W       (UP_IO_W),
        .IO_GRAN_BITS  (IO_GRAN_BITS),
        .MEM_GRAN_BITS (MEM_GRAN_BITS),
        .MASK_IO_HIGH  (1'b0)
    ) u_dn (
        .addr      (dn_addr),
        .is_io     (dn_is_io),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .mem_base  (mem_base),
        .mem_limit (mem_limit),
        .io_hit    (dn_io_hit),
        .np_hit    (dn_np_hit),
        .pf_hit    (dn_pf_hit),
        .target    (dn_target)
    );
endmodule

// File: rtl/bwd_checker.sv
`timescale 1ns/1ps
// Module: bwd_checker
// Temporal and relational properties for bridge_window_decoder, bound in.
module bwd_checker
    import bwd_pkg::*;
#(
    parameter int UP_TOP_W    = 8,
    parameter int DN_TOP_W    = 7,
    parameter int IO_FIELD_W  = 13,
    parameter int MEM_FIELD_W = 12,
    parameter int DATA_W      = 32
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    cfg_wr_en,
    input logic [REG_IDX_W-1:0]                    cfg_addr,
    input logic [DATA_W-1:0]                       cfg_wdata,
    input logic [DATA_W-1:0]                       cfg_rdata,
    input logic [UP_TOP_W-1:0]                     up_top,
    input logic                                    up_is_io,
    input logic [DN_TOP_W-1:0]                     dn_top,
    input logic                                    dn_is_io,
    input logic                                    up_io_hit,
    input logic                                    up_np_hit,
    input logic                                    up_pf_hit,
    input logic                                    dn_io_hit,
    input logic                                    dn_np_hit,
    input logic                                    dn_pf_hit,
    input logic [IO_FIELD_W-1:0]                   io_base,
    input logic [IO_FIELD_W-1:0]                   io_limit,
    input logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_base,
    input logic [NUM_MEM_WIN-1:0][MEM_FIELD_W-1:0] mem_limit
);
    // R2: a bus register write is readable on the next cycle at that index
    a_r2_busnum_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == REG_BUSNUM) |=>
        ((cfg_addr != REG_BUSNUM) || (cfg_rdata == $past(cfg_wdata))));

    // R6: upstream memory above 4 GB never hits a memory window
    a_r6_above_4g: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_is_io && (|up_top)) |-> (!up_np_hit && !up_pf_hit));

    // R8: downstream IO with top bits set never hits
    a_r8_dn_io_top: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_is_io && (|dn_top)) |-> !dn_io_hit);

    // R9: disabled windows never hit on either side
    a_r9_io_off: assert property (@(posedge clk) disable iff (!rst_n)
        (io_base > io_limit) |-> (!up_io_hit && !dn_io_hit));
    a_r9_np_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_base[0] > mem_limit[0]) |-> (!up_np_hit && !dn_np_hit));
    a_r9_pf_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_base[1] > mem_limit[1]) |-> (!up_pf_hit && !dn_pf_hit));

    // R10: access kind separates IO hits from memory hits
    a_r10_up_kind: assert property (@(posedge clk) disable iff (!rst_n)
        up_is_io ? (!up_np_hit && !up_pf_hit) : !up_io_hit);
    a_r10_dn_kind: assert property (@(posedge clk) disable iff (!rst_n)
        dn_is_io ? (!dn_np_hit && !dn_pf_hit) : !dn_io_hit);
endmodule

bind bridge_window_decoder bwd_checker #(
    .UP_TOP_W    (UP_ADDR_W - DN_ADDR_W),
    .DN_TOP_W    (DN_ADDR_W - UP_IO_W),
    .IO_FIELD_W  (IO_FIELD_W),
    .MEM_FIELD_W (MEM_FIELD_W),
    .DATA_W      (CFG_DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .up_top    (up_addr[UP_ADDR_W-1:DN_ADDR_W]),
    .up_is_io  (up_is_io),
    .dn_top    (dn_addr[DN_ADDR_W-1:UP_IO_W]),
    .dn_is_io  (dn_is_io),
    .up_io_hit (up_io_hit),
    .up_np_hit (up_np_hit),
    .up_pf_hit (up_pf_hit),
    .dn_io_hit (dn_io_hit),
    .dn_np_hit (dn_np_hit),
    .dn_pf_hit (dn_pf_hit),
    .io_base   (io_base),
    .io_limit  (io_limit),
    .mem_base  (mem_base),
    .mem_limit (mem_limit)
);

// File: tb/bridge_window_decoder_test.sv
`timescale 1ns/1ps
// Bench: behavioural model of the register file and windows, compared on
// every falling clock edge against all decode outputs and the read port.
module bridge_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic [39:0] up_addr = 40'd0;
    logic        up_is_io = 1'b0;
    logic [31:0] dn_addr = 32'd0;
    logic        dn_is_io = 1'b0;
    logic up_io_hit, up_np_hit, up_pf_hit, up_target;
    logic dn_io_hit, dn_np_hit, dn_pf_hit, dn_target;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";
    logic [31:0] m_reg [4] = '{default: 32'd0};

    always #2.5 clk = ~clk;

    bridge_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .up_addr(up_addr), .up_is_io(up_is_io), .dn_addr(dn_addr), .dn_is_io(dn_is_io),
        .up_io_hit(up_io_hit), .up_np_hit(up_np_hit), .up_pf_hit(up_pf_hit), .up_target(up_target),
        .dn_io_hit(dn_io_hit), .dn_np_hit(dn_np_hit), .dn_pf_hit(dn_pf_hit), .dn_target(dn_target)
    );

    function automatic logic [31:0] impl_mask(int idx);
        if (idx == 0) return 32'hFFFF_FFFF;
        if (idx == 1) return 32'h1FFF_1FFF;
        return 32'hFFF0_FFF0;
    endfunction

    // Expected {target, pf, np, io} from full-address range arithmetic.
    function automatic logic [3:0] expect_hits(longint a, bit io, bit upstream);
        longint lo, hi, ea;
        logic h_io, h_np, h_pf;
        h_io = 0; h_np = 0; h_pf = 0;
        if (io) begin
            ea = upstream ? (a & 64'h1FF_FFFF) : a;
            if (upstream || (a >> 25) == 0) begin
                lo = longint'(m_reg[1][12:0]) * 4096;
                hi = longint'(m_reg[1][28:16]) * 4096 + 4095;
                h_io = (ea >= lo) && (ea <= hi);
            end
        end else if (a <= 64'hFFFF_FFFF) begin
            lo = longint'(m_reg[2][15:4]) * 1048576;
            hi = longint'(m_reg[2][31:20]) * 1048576 + 1048575;
            h_np = (a >= lo) && (a <= hi);
            lo = longint'(m_reg[3][15:4]) * 1048576;
            hi = longint'(m_reg[3][31:20]) * 1048576 + 1048575;
            h_pf = (a >= lo) && (a <= hi);
        end
        return {h_io | h_np | h_pf, h_pf, h_np, h_io};
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference register state, updated on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] <= 32'd0;
        end else if (cfg_wr_en) begin
            m_reg[cfg_addr] <= cfg_wdata & impl_mask(int'(cfg_addr));
        end
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        logic [3:0] eu, ed;
        if (!done) begin
            eu = expect_hits(longint'(up_addr), up_is_io, 1'b1);
            ed = expect_hits(longint'(dn_addr), dn_is_io, 1'b0);
            check(cur_tag, "cfg_rdata", 64'(cfg_rdata), 64'(m_reg[cfg_addr]));
            check(cur_tag, "up_io_hit", 64'(up_io_hit), 64'(eu[0]));
            check(cur_tag, "up_np_hit", 64'(up_np_hit), 64'(eu[1]));
            check(cur_tag, "up_pf_hit", 64'(up_pf_hit), 64'(eu[2]));
            check("R11",   "up_target", 64'(up_target), 64'(eu[3]));
            check(cur_tag, "dn_io_hit", 64'(dn_io_hit), 64'(ed[0]));
            check(cur_tag, "dn_np_hit", 64'(dn_np_hit), 64'(ed[1]));
            check(cur_tag, "dn_pf_hit", 64'(dn_pf_hit), 64'(ed[2]));
            check("R11",   "dn_target", 64'(dn_target), 64'(ed[3]));
        end
    end

    task automatic cfg_write(int idx, logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_addr = 2'(idx); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic probe(logic [39:0] ua, bit uio, logic [31:0] da, bit dio);
        @(posedge clk); #1;
        up_addr = ua; up_is_io = uio; dn_addr = da; dn_is_io = dio;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL [R12] watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state on every index, during and after reset
        cur_tag = "R1";
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1; cfg_addr = 2'(i);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1; cfg_addr = 2'(i);
        end
        // R2: bus register, all bits writable
        cur_tag = "R2";
        cfg_write(0, 32'hA5C3_1E07);
        cfg_write(0, 32'h5A3C_E1F8);
        // R3: unimplemented bits read zero
        cur_tag = "R3";
        cfg_write(1, 32'hFFFF_FFFF);
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_write(3, 32'hFFFF_FFFF);
        cfg_write(1, 32'h0015_0012);   // IO 0x12000..0x15FFF
        cfg_write(2, 32'h1FF0_1000);   // NP 0x10000000..0x1FFFFFFF
        cfg_write(3, 32'h8FF0_8000);   // PF 0x80000000..0x8FFFFFFF
        // R4: non-prefetchable edges
        cur_tag = "R4";
        probe(40'h0_0FFF_FFFF, 0, 32'h0FFF_FFFF, 0);
        probe(40'h0_1000_0000, 0, 32'h1000_0000, 0);
        probe(40'h0_1FFF_FFFF, 0, 32'h1FFF_FFFF, 0);
        probe(40'h0_2000_0000, 0, 32'h2000_0000, 0);
        // R5: prefetchable edges
        cur_tag = "R5";
        probe(40'h0_7FFF_FFFF, 0, 32'h7FFF_FFFF, 0);
        probe(40'h0_8000_0000, 0, 32'h8000_0000, 0);
        probe(40'h0_8FFF_FFFF, 0, 32'h8FFF_FFFF, 0);
        probe(40'h0_9000_0000, 0, 32'h9000_0000, 0);
        // R6: above 4 GB upstream
        cur_tag = "R6";
        probe(40'h01_1000_0000, 0, 32'h1000_0000, 0);
        probe(40'h80_8000_0000, 0, 32'h8000_0000, 0);
        // R7: IO edges and upstream high-bit masking
        cur_tag = "R7";
        probe(40'h0_0001_1FFF, 1, 32'h0001_1FFF, 1);
        probe(40'h0_0001_2000, 1, 32'h0001_2000, 1);
        probe(40'h0_0001_5FFF, 1, 32'h0001_5FFF, 1);
        probe(40'h0_0001_6000, 1, 32'h0001_6000, 1);
        probe(40'hFF_FE01_4000, 1, 32'h0001_4000, 1);
        // R8: downstream IO with top bits set
        cur_tag = "R8";
        probe(40'h0_0001_4000, 1, 32'h0201_4000, 1);
        probe(40'h0_0001_3000, 1, 32'h8001_3000, 1);
        // R10: kind mismatch
        cur_tag = "R10";
        probe(40'h0_1000_0000, 1, 32'h8000_0000, 1);
        probe(40'h0_0001_3000, 0, 32'h0001_3000, 0);
        // R9: base above limit
        cur_tag = "R9";
        cfg_write(2, 32'h2FF0_3000);
        probe(40'h0_2FF0_0000, 0, 32'h3000_0000, 0);
        cfg_write(1, 32'h0011_0012);
        probe(40'h0_0001_1000, 1, 32'h0001_2000, 1);
        cfg_write(3, 32'h7FF0_8000);
        probe(40'h0_8000_0000, 0, 32'h7FF0_0000, 0);
        // R12: address changes every cycle, windows re-enabled
        cur_tag = "R12";
        cfg_write(2, 32'h1FF0_1000);
        cfg_write(1, 32'h0015_0012);
        for (int i = 0; i < 16; i++) begin
            probe({8'h0, 4'h1, 28'(i * 32'h0010_0000)}, i[0],
                  32'h0001_0000 + 32'(i * 4096), i[1]);
        end
        // R11: mixed random traffic with occasional reprogramming
        cur_tag = "R11";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [39:0] ua;
            logic [31:0] da;
            if (i % 50 == 0) begin
                cfg_write(1 + (i / 50) % 3, $urandom);
            end
            r  = $urandom;
            ua = {($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00, $urandom};
            da = $urandom;
            if (r[0]) da[31:25] = 7'd0;
            if (r[1]) ua[31:17] = 15'd0;
            if (r[2]) da[31:17] = 15'd0;
            probe(ua, r[3], da, r[4]);
        end
        @(posedge clk); #1;
        finish_run();
    end
endmodule